// File: doc/BRIEF.md
# NVM Checksum Sequencer

This block walks the low words of a word-addressed non-volatile memory through a simple request and done port. It has two operations. The check operation adds up every word from address 0 through the checksum slot. The fix operation adds up every word below the checksum slot and then writes the checksum word. All sums are 16-bit and wrap around.

After a check, the block reports whether the total matched the fixed signature 0xBABA. After a fix, the checksum slot holds the value that brings the full sum to that signature. A controller pulses `start_i` with `mode_i` selecting the operation, then waits for the one-cycle `done_o`. The `err_o` and `valid_o` flags stay readable until the next accepted start.

The port side carries one transfer at a time. `mem_req_o` stays high with a stable address, direction and write data until the memory answers with `mem_done_i` (success) or `mem_err_i` (failure). `mem_req_o` then drops for at least one cycle. An error on any transfer ends the operation at once.

Top module: `nvm_sum_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `valid_o` and `mem_req_o` are all 0, and `mem_req_o` is never high while `busy_o` is low.
- R2: A check operation (`mode_i`=0) issues reads (`mem_we_o`=0) to addresses 0, 1, … up to and including SUM_IDX (default 0x3F), one word per request, in ascending order, with no write.
- R3: At the end of a successful check, `valid_o` is 1 exactly when the 16-bit wrapping sum of the words read equals 0xBABA, and `err_o` is 0.
- R4: A fix operation (`mode_i`=1) reads addresses 0 through SUM_IDX-1 in ascending order. It then issues exactly one write (`mem_we_o`=1) to SUM_IDX carrying 0xBABA minus the 16-bit wrapping sum of those words. It ends with `err_o`=0 and `valid_o`=0.
- R5: When `mem_err_i` answers a read, the operation ends: `done_o` and `err_o` are 1 in the next cycle, `valid_o` is 0, and no further request is issued.
- R6: When `mem_err_i` answers the checksum write of a fix operation, `done_o` and `err_o` are 1 in the next cycle.
- R7: `done_o` is high for exactly one cycle per operation. `err_o` and `valid_o` keep their final values until the next accepted start, which clears both.
- R8: `start_i` is ignored while `busy_o` is high: the running operation neither restarts nor changes mode.
- R9: While `mem_req_o` is high and no response has arrived, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stay stable. In the cycle after a response, `mem_req_o` is low, so at most one transfer is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when idle |
| mode_i | input | 1 | 0 = check sum, 1 = fix checksum word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Last operation ended on a port error |
| valid_o | output | 1 | Last check found the signature |
| mem_req_o | output | 1 | Transfer request, held until answered |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid with `mem_done_i` |
| mem_done_i | input | 1 | Transfer completed |
| mem_err_i | input | 1 | Transfer failed |

## Verification
Several rules are checked on every cycle: the port handshake holds its address, direction and data while waiting, drops the request after each response, and writes only to the checksum slot. The checks also cover the one-cycle done pulse, the abort right after a port error, the retention of the result flags while idle, and the absence of any request while idle. Only the bench scenarios can show the arithmetic and the access counts. These include the exact word written by a fix (also with all-ones words that wrap the sum), the pass and fail verdicts of a check, the number and order of reads before an abort at the first and at a middle address, the untouched checksum slot after a failed write, and a start pulse ignored during a run.

// File: rtl/nvm_sum_pkg.sv
package nvm_sum_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_GAP  = 2'd2,
      ST_WR   = 2'd3
   } nvm_sum_st_e;

   typedef enum logic {
      OP_CHECK = 1'b0,
      OP_FIX   = 1'b1
   } nvm_sum_op_e;

endpackage

// File: rtl/nvm_sum_acc.sv
module nvm_sum_acc #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              add_i,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] sum_o,
   output logic [DATA_W-1:0] sum_next_o
);

   logic [DATA_W-1:0] sum_q;

   // modulo 2^DATA_W: the carry out is simply dropped
   assign sum_next_o = sum_q + word_i;
   assign sum_o      = sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
      end else if (clr_i) begin
         sum_q <= '0;
      end else if (add_i) begin
         sum_q <= sum_next_o;
      end
   end

endmodule

// File: rtl/nvm_sum_idx.sv
module nvm_sum_idx #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              inc_i,
   output logic [ADDR_W-1:0] idx_o
);

   logic [ADDR_W-1:0] idx_q;

   assign idx_o = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clr_i) begin
         idx_q <= '0;
      end else if (inc_i) begin
         idx_q <= idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/nvm_sum_seq.sv
module nvm_sum_seq
   import nvm_sum_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned SUM_IDX   = 'h3F,
   parameter int unsigned SIGNATURE = 'hBABA,
   parameter bit          WDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              valid_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_done_i,
   input  logic              mem_err_i
);

   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(SUM_IDX);
   localparam logic [DATA_W-1:0] SIG      = DATA_W'(SIGNATURE);

   // elaboration-time parameter checks
   if (SUM_IDX < 1 || SUM_IDX >= (64'd1 << ADDR_W)) begin : g_bad_idx
      $error("nvm_sum_seq: SUM_IDX must lie in 1 .. 2**ADDR_W-1");
   end
   if (DATA_W < 2 || SIGNATURE >= (64'd1 << DATA_W)) begin : g_bad_sig
      $error("nvm_sum_seq: SIGNATURE must fit in DATA_W bits");
   end

   nvm_sum_st_e       state_q;
   nvm_sum_op_e       mode_q;
   logic              done_q;
   logic              err_q;
   logic              valid_q;

   logic              accept;
   logic              rd_ok;
   logic              fin_rd;
   logic [ADDR_W-1:0] idx;
   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] sum_next;
   logic [DATA_W-1:0] wdata;

   assign accept = (state_q == ST_IDLE) && start_i;
   assign rd_ok  = (state_q == ST_RD) && mem_done_i && !mem_err_i;
   // a check ends on the read of the checksum slot itself
   assign fin_rd = (mode_q == OP_CHECK) && (idx == LAST_IDX);

   nvm_sum_acc #(.DATA_W(DATA_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (accept),
      .add_i      (rd_ok),
      .word_i     (mem_rdata_i),
      .sum_o      (sum),
      .sum_next_o (sum_next)
   );

   nvm_sum_idx #(.ADDR_W(ADDR_W)) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (accept),
      .inc_i (rd_ok && !fin_rd),
      .idx_o (idx)
   );

   // write data: registered during the gap cycle, or taken straight from the sum
   if (WDATA_REG) begin : g_wd_reg
      logic [DATA_W-1:0] wdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wdata_q <= '0;
         end else if (state_q == ST_GAP) begin
            wdata_q <= SIG - sum;
         end
      end
      assign wdata = wdata_q;
   end else begin : g_wd_comb
      assign wdata = SIG - sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= OP_CHECK;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  mode_q  <= nvm_sum_op_e'(mode_i);
                  err_q   <= 1'b0;
                  valid_q <= 1'b0;
                  state_q <= ST_RD;
               end
            end
            ST_RD: begin
               if (mem_err_i) begin
                  err_q   <= 1'b1;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (mem_done_i) begin
                  if (fin_rd) begin
                     valid_q <= (sum_next == SIG);
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_GAP;
                  end
               end
            end
            ST_GAP: begin
               state_q <= ((mode_q == OP_FIX) && (idx == LAST_IDX)) ? ST_WR : ST_RD;
            end
            ST_WR: begin
               if (mem_err_i || mem_done_i) begin
                  err_q   <= mem_err_i;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign valid_o     = valid_q;
   assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
   assign mem_we_o    = (state_q == ST_WR);
   assign mem_addr_o  = idx;
   assign mem_wdata_o = wdata;

endmodule

// File: rtl/nvm_sum_seq_chk.sv
module nvm_sum_seq_chk #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned SUM_IDX = 'h3F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic              valid_o,
   input logic              mem_req_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic              mem_done_i,
   input logic              mem_err_i
);

   // R1
   idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_done_i && !mem_err_i) |=>
         (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

   // R9
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && (mem_done_i || mem_err_i)) |=> !mem_req_o);

   // R4
   write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> (mem_addr_o == ADDR_W'(SUM_IDX)));

   // R5
   abort_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_err_i) |=> (done_o && err_o && !valid_o));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(err_o) && $stable(valid_o)));

   // R3
   pass_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && valid_o) |-> !err_o);

endmodule

bind nvm_sum_seq nvm_sum_seq_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .SUM_IDX (SUM_IDX)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .err_o       (err_o),
   .valid_o     (valid_o),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_done_i  (mem_done_i),
   .mem_err_i   (mem_err_i)
);

// File: tb/nvm_sum_seq_test.sv
module nvm_sum_seq_test;

   localparam int AW   = 8;
   localparam int DW   = 16;
   localparam int SIDX = 'h3F;
   localparam logic [15:0] SIGV = 16'hBABA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          mode_i = 1'b0;
   logic          busy_o, done_o, err_o, valid_o;
   logic          mem_req_o, mem_we_o;
   logic [AW-1:0] mem_addr_o;
   logic [DW-1:0] mem_wdata_o;
   logic [DW-1:0] mem_rdata_i = '0;
   logic          mem_done_i = 1'b0;
   logic          mem_err_i = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   nvm_sum_seq uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .valid_o(valid_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .mem_done_i(mem_done_i), .mem_err_i(mem_err_i)
   );

   int total = 0;
   int bad   = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [15:0] mem [256];
   int          lat = 1;
   int          wait_cnt = 0;
   bit          inject = 1'b0;
   int          err_addr = 0;
   int          rd_cnt = 0, wr_cnt = 0, nxt_addr = 0;
   int          seq_bad = 0, proto_bad = 0;
   logic        resp_d = 1'b0;
   logic        req_d = 1'b0;
   logic [AW-1:0] addr_d = '0;
   logic        we_d = 1'b0;

   always @(posedge clk) begin
      mem_done_i <= 1'b0;
      mem_err_i  <= 1'b0;
      resp_d     <= mem_done_i | mem_err_i;
      req_d      <= mem_req_o && !mem_done_i && !mem_err_i;
      addr_d     <= mem_addr_o;
      we_d       <= mem_we_o;
      if (resp_d && mem_req_o) proto_bad++;
      if (req_d && (!mem_req_o || mem_addr_o != addr_d || mem_we_o != we_d)) proto_bad++;
      if (start_i && !busy_o) begin
         rd_cnt = 0; wr_cnt = 0; nxt_addr = 0;
      end
      if (mem_req_o && !mem_done_i && !mem_err_i) begin
         if (wait_cnt >= lat) begin
            wait_cnt <= 0;
            if (inject && int'(mem_addr_o) == err_addr) begin
               mem_err_i <= 1'b1;
            end else begin
               mem_done_i <= 1'b1;
               if (mem_we_o) begin
                  mem[mem_addr_o] <= mem_wdata_o;
                  wr_cnt++;
               end else begin
                  mem_rdata_i <= mem[mem_addr_o];
                  if (int'(mem_addr_o) != nxt_addr) seq_bad++;
                  nxt_addr++;
                  rd_cnt++;
               end
            end
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      bit          e_err;
      bit          e_valid;
      int          e_rd;
      int          e_wr;
      bit          chk_w;
      logic [15:0] e_word;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int   issued = 0;
   int   seen = 0;

   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(err_o == e.e_err, e.req, "err_o", 32'(err_o), 32'(e.e_err));
            check(valid_o == e.e_valid, e.req, "valid_o", 32'(valid_o), 32'(e.e_valid));
            check(rd_cnt == e.e_rd, e.req, "read count", 32'(rd_cnt), 32'(e.e_rd));
            check(wr_cnt == e.e_wr, e.req, "write count", 32'(wr_cnt), 32'(e.e_wr));
            // R2 ascending single-word reads
            check(seq_bad == 0, "R2", "read order faults", 32'(seq_bad), 32'd0);
            // R9 handshake stability and request gap
            check(proto_bad == 0, "R9", "handshake faults", 32'(proto_bad), 32'd0);
            if (e.chk_w)
               check(mem[SIDX] == e.e_word, e.req, "checksum word", 32'(mem[SIDX]), 32'(e.e_word));
         end
         seen++;
      end
   end

   function automatic logic [15:0] sum_to(input int n);
      logic [15:0] s = '0;
      for (int i = 0; i < n; i++) s = s + mem[i];
      return s;
   endfunction

   task automatic run_op(input bit fix, input bit e_err, input bit e_valid,
                         input int e_rd, input int e_wr, input bit chk_w,
                         input logic [15:0] e_word, input string req, input bit poke);
      exp_t e;
      e.e_err = e_err; e.e_valid = e_valid; e.e_rd = e_rd; e.e_wr = e_wr;
      e.chk_w = chk_w; e.e_word = e_word; e.req = req;
      exp_q.push_back(e);
      issued++;
      @(negedge clk); start_i = 1'b1; mode_i = fix;
      @(negedge clk); start_i = 1'b0;
      if (poke) begin
         // R8: a start while busy, with the other mode
         repeat (5) @(negedge clk);
         start_i = 1'b1; mode_i = ~fix;
         @(negedge clk); start_i = 1'b0;
      end
      while (seen < issued) @(negedge clk);
      repeat (3) @(negedge clk);
      // R7 flags held, done gone
      check(done_o == 1'b0, "R7", "done after pulse", 32'(done_o), 32'd0);
      check(err_o == e_err && valid_o == e_valid, "R7", "held flags",
            {30'd0, err_o, valid_o}, {30'd0, e_err, e_valid});
   endtask

   // ---------------- watchdog ----------------
   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(1'b0, "WD", "watchdog expired", 32'(cycles), 32'd150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [15:0] w;
      for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0F31) ^ 16'h5A5A;
      repeat (3) @(negedge clk);
      // R1 reset state
      check({busy_o, done_o, err_o, valid_o, mem_req_o} == 5'b0, "R1", "reset outputs",
            32'({busy_o, done_o, err_o, valid_o, mem_req_o}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!mem_req_o && !busy_o, "R1", "idle after reset", 32'(mem_req_o), 32'd0);

      // R4 fix on a patterned image
      w = SIGV - sum_to(SIDX);
      run_op(1'b1, 1'b0, 1'b0, SIDX, 1, 1'b1, w, "R4", 1'b0);
      // R3 check now passes (R2: SIDX+1 reads)
      run_op(1'b0, 1'b0, 1'b1, SIDX + 1, 0, 1'b0, '0, "R3", 1'b0);
      // R3 corrupt one word: fails
      mem[5] = mem[5] ^ 16'h0001;
      run_op(1'b0, 1'b0, 1'b0, SIDX + 1, 0, 1'b0, '0, "R3", 1'b0);

      // R4 wraparound: all-ones image
      for (int i = 0; i <= SIDX; i++) mem[i] = 16'hFFFF;
      w = SIGV - sum_to(SIDX);
      run_op(1'b1, 1'b0, 1'b0, SIDX, 1, 1'b1, w, "R4", 1'b0);
      run_op(1'b0, 1'b0, 1'b1, SIDX + 1, 0, 1'b0, '0, "R3", 1'b0);

      // R5 read error mid-check, slower port
      lat = 3; inject = 1'b1; err_addr = 10;
      run_op(1'b0, 1'b1, 1'b0, 10, 0, 1'b0, '0, "R5", 1'b0);
      // R5 read error on the first word of a fix
      err_addr = 0;
      run_op(1'b1, 1'b1, 1'b0, 0, 0, 1'b1, mem[SIDX], "R5", 1'b0);
      // R6 write error: checksum slot unchanged
      err_addr = SIDX;
      mem[3] = 16'h1234;
      run_op(1'b1, 1'b1, 1'b0, SIDX, 0, 1'b1, mem[SIDX], "R6", 1'b0);

      // R7 error cleared by next start; R3 still fails after word 3 edit
      inject = 1'b0; lat = 1;
      run_op(1'b0, 1'b0, 1'b0, SIDX + 1, 0, 1'b0, '0, "R7", 1'b0);

      // R8 start ignored while busy
      run_op(1'b0, 1'b0, 1'b0, SIDX + 1, 0, 1'b0, '0, "R8", 1'b1);

      // R4 zero-latency fix, then passing check
      lat = 0;
      w = SIGV - sum_to(SIDX);
      run_op(1'b1, 1'b0, 1'b0, SIDX, 1, 1'b1, w, "R4", 1'b0);
      run_op(1'b0, 1'b0, 1'b1, SIDX + 1, 0, 1'b0, '0, "R3", 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule